// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

This block is a clock-accurate, synthesizable model of a synchronous burst SRAM with a two-stage read pipeline. It holds a small array of words split into byte lanes. It behaves at its pins like a bus-side static memory. Accesses open when either of two address strobes is sampled low. The processor-side strobe wins over the controller-side strobe and can be masked by the first chip enable. A 2-bit counter then walks up to four locations in interleaved or linear order. Each further cycle either advances that counter or holds on the current location.

Writes are steered by three controls: a global write that covers every lane, and a byte-write enable combined with one select per lane. A burst opened by the controller strobe can write on its opening edge. A burst opened by the processor strobe always starts with a read, so the earliest it can write is the following edge. The data outputs use a separate read bus plus a drive flag instead of a tristate. A sleep input, handled as a clocked state, freezes the model while keeping the array contents.

Top module: `burst_sram`

## Requirements
- R1: After the synchronous reset `rst`, the model is deselected and `q_drive` is low. Cycles that carry no strobe perform no access until a burst has been opened.
- R2: A burst opens only when a strobe is honoured and all three enables are active (`en_lo0_n`=0, `en_hi`=1, `en_lo1_n`=0). An honoured strobe with any enable inactive deselects the model, and later cycles without a strobe then perform no access.
- R3: When both strobes are low, only `start_cpu_n` counts, so the cycle is a read whatever the write controls say. `start_cpu_n` is ignored while `en_lo0_n` is high, and that cycle then acts as a cycle with no strobe.
- R4: `start_ctl_n` low, with `start_cpu_n` high and the write controls asserted, writes `wdata` to `addr` on that same edge. `step_n` is ignored in that cycle.
- R5: A `start_cpu_n` cycle reads its address even when write controls are asserted. A write happens on the next edge, with both strobes high, using the write controls and `wdata` of that edge.
- R6: With both strobes high during an open burst, `step_n`=0 accesses the next burst address and `step_n`=1 re-accesses the current one. This holds for reads and for writes.
- R7: With `order_ilv`=1, the low two address bits of burst access c are (start bits) XOR (c mod 4).
- R8: With `order_ilv`=0, the low two address bits of burst access c are (start bits + c) mod 4.
- R9: `wr_all_n`=0 writes all lanes. Otherwise `wr_lane_n`=0 writes exactly the lanes whose `lane_sel_n` bit i is 0, where lane i is `wdata[9i+8:9i]`. If neither write control is asserted, or no lane is selected, the cycle is a read.
- R10: Data of a read sampled at edge k is on `rdata`, with `q_drive` high, after edge k+1. If edge k-1 carried no read, `q_drive` is low between edges k and k+1.
- R11: `q_drive` is low whenever `out_en_n` is high, and also whenever the current inputs decode a write.
- R12: When a read is followed by a deselect, the read data is still driven after the deselect edge, and `q_drive` goes low after the next edge.
- R13: Once `doze` has been high for two edges, strobes and writes are ignored, `q_drive` goes low and any open burst is dropped. After `doze` returns low, two more edges are ignored. The array contents are kept throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampled inputs are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, sampled on a strobe edge |
| en_lo0_n | input | 1 | First chip enable, active low; also masks the processor strobe |
| en_hi | input | 1 | Second chip enable, active high |
| en_lo1_n | input | 1 | Third chip enable, active low |
| start_cpu_n | input | 1 | Processor-side address strobe, active low, higher priority |
| start_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low; high suspends on the current address |
| wr_all_n | input | 1 | Global write, active low, overrides the lane controls |
| wr_lane_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, applied combinationally |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| doze | input | 1 | Sleep request, active high |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| q_drive | output | 1 | High when `rdata` would be driven onto a shared bus |

## Verification
The two functions most likely to meet in one cycle are the read pipeline and a write. Read data still leaving the output register can coincide with a write being presented. The bench sets this up with a two-cycle processor-strobe write: the opening read returns its data on the very edge where the second-cycle write is decoded. The check is that `rdata` shows the pre-write word while `q_drive` stays low. A second collision is a burst in flight when sleep begins. It is provoked by opening a burst in the two awake edges after `doze` rises. After wake-up, the bench sends continue-with-write cycles and confirms through read-back that the neighbouring word was never touched.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  // low two address bits for burst step cnt from origin org
  function automatic logic [1:0] burst_low(input logic [1:0] org,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (org ^ cnt) : (org + cnt);
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SLEEP_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_lo0_n,
  input  logic             en_hi,
  input  logic             en_lo1_n,
  input  logic             start_cpu_n,
  input  logic             start_ctl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             doze,
  output op_e              op,
  output logic             load,
  output logic             adv,
  output logic [LANES-1:0] lane_we,
  output logic             asleep
);

  logic [SLEEP_LAT-1:0] slp_q;
  logic                 active_q;
  logic [LANES-1:0]     wmask;
  logic                 cpu_seen;
  logic                 any_strobe;
  logic                 chips_on;

  generate
    if (SLEEP_LAT == 1) begin : g_slp_one
      always_ff @(posedge clk) begin
        if (rst) slp_q <= '0;
        else     slp_q <= doze;
      end
    end else begin : g_slp_chain
      always_ff @(posedge clk) begin
        if (rst) slp_q <= '0;
        else     slp_q <= {slp_q[SLEEP_LAT-2:0], doze};
      end
    end
  endgenerate

  assign asleep = slp_q[SLEEP_LAT-1];

  // global write overrides the lane controls
  always_comb begin
    wmask = '0;
    if (!wr_all_n)       wmask = '1;
    else if (!wr_lane_n) wmask = ~lane_sel_n;
  end

  assign cpu_seen   = !start_cpu_n && !en_lo0_n;
  assign any_strobe = cpu_seen || !start_ctl_n;
  assign chips_on   = !en_lo0_n && en_hi && !en_lo1_n;

  always_comb begin
    op   = OP_NONE;
    load = 1'b0;
    adv  = 1'b0;
    if (!asleep) begin
      if (any_strobe) begin
        if (!chips_on) begin
          op = OP_DESEL;
        end else begin
          load = 1'b1;
          op   = (cpu_seen || wmask == '0) ? OP_READ : OP_WRITE;
        end
      end else if (active_q) begin
        adv = !step_n;
        op  = (wmask == '0) ? OP_READ : OP_WRITE;
      end
    end
  end

  assign lane_we = (op == OP_WRITE) ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst)                          active_q <= 1'b0;
    else if (asleep || op == OP_DESEL) active_q <= 1'b0;
    else if (load)                    active_q <= 1'b1;
  end

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DESEL) |=> (load || op == OP_NONE || op == OP_DESEL));

  // R13
  doze_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |-> (op == OP_NONE && lane_we == '0 && !load));

  // R3
  cpu_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_cpu_n && !start_ctl_n && !en_lo0_n) |-> (lane_we == '0));

endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q;
  logic [1:0]      org_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      org_q  <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr[ADDR_W-1:2];
      org_q  <= addr[1:0];
      cnt_q  <= '0;
    end else if (adv) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign cnt_use  = adv ? cnt_q + 2'd1 : cnt_q;
  assign acc_addr = load ? addr : {base_q, burst_low(org_q, cnt_use, order_ilv)};

  // R6
  hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(cnt_q));

  // R6
  step_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R7
  load_org_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == 2'd0 && org_q == $past(addr[1:0])));

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output wire  [LANES*LANE_W-1:0] rd_q
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[addr] <= wdata[l*LANE_W +: LANE_W];
      if (rd_en)      q         <= mem[addr];
    end

    assign rd_q[l*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter  int ADDR_W    = 8,
  parameter  int LANES     = 4,
  parameter  int LANE_W    = 9,
  parameter  int SLEEP_LAT = 2,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_lo0_n,
  input  logic              en_hi,
  input  logic              en_lo1_n,
  input  logic              start_cpu_n,
  input  logic              start_ctl_n,
  input  logic              step_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic              order_ilv,
  input  logic              doze,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              q_drive
);

  op_e               op;
  logic              load;
  logic              adv;
  logic [LANES-1:0]  lane_we;
  logic              asleep;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] ram_q;
  logic              rd1_q;
  logic              outv_q;
  logic [DATA_W-1:0] out_q;

  burst_sram_ctrl #(.LANES(LANES), .SLEEP_LAT(SLEEP_LAT)) u_ctrl (
    .clk(clk), .rst(rst),
    .en_lo0_n(en_lo0_n), .en_hi(en_hi), .en_lo1_n(en_lo1_n),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_sel_n(lane_sel_n),
    .doze(doze),
    .op(op), .load(load), .adv(adv), .lane_we(lane_we), .asleep(asleep)
  );

  burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .order_ilv(order_ilv),
    .addr(addr), .acc_addr(acc_addr)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .lane_we(lane_we), .rd_en(op == OP_READ),
    .addr(acc_addr), .wdata(wdata), .rd_q(ram_q)
  );

  // second pipeline stage: array word into the output register
  always_ff @(posedge clk) begin
    if (rst || asleep) begin
      rd1_q  <= 1'b0;
      outv_q <= 1'b0;
    end else begin
      rd1_q  <= (op == OP_READ);
      outv_q <= rd1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        out_q <= '0;
    else if (rd1_q) out_q <= ram_q;
  end

  assign rdata   = out_q;
  assign q_drive = !out_en_n && outv_q && (op != OP_WRITE);

  // R10
  read_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_READ) ##1 !asleep |=> outv_q);

  // R12
  desel_hz_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DESEL) |=> ##1 !outv_q);

  // R13
  sleep_hz_chk: assert property (@(posedge clk) disable iff (rst)
    asleep |=> !outv_q);

endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;

  localparam int AW    = 8;
  localparam int NL    = 4;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          en_lo0_n, en_hi, en_lo1_n;
  logic          start_cpu_n, start_ctl_n, step_n;
  logic          wr_all_n, wr_lane_n;
  logic [NL-1:0] lane_sel_n;
  logic          out_en_n, order_ilv, doze;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          q_drive;

  always #4 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .SLEEP_LAT(2)) i_burst_sram (
    .clk(clk), .rst(rst), .addr(addr),
    .en_lo0_n(en_lo0_n), .en_hi(en_hi), .en_lo1_n(en_lo1_n),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .order_ilv(order_ilv), .doze(doze),
    .wdata(wdata), .rdata(rdata), .q_drive(q_drive)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();
    en_lo0_n = 1'b0; en_hi = 1'b1; en_lo1_n = 1'b0;
    start_cpu_n = 1'b1; start_ctl_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; wr_lane_n = 1'b1; lane_sel_n = '1;
    out_en_n = 1'b0; wdata = '0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    longint v;
    v = (longint'(a) + 1) * 64'd2654435761 + longint'(salt) * 64'd40503 + 64'h5A5;
    return v[DW-1:0];
  endfunction

  function automatic int lowb(input int s, input int c, input int m);
    return (m != 0) ? (s ^ (c & 3)) : ((s + c) & 3);
  endfunction

  // read one word through the pins, then deselect; check data and drive flag
  task automatic rd_chk(input int a, input string req);
    nop(); start_ctl_n = 1'b0; addr = AW'(a); cyc();
    nop(); start_ctl_n = 1'b0; en_hi = 1'b0; cyc();
    nop(); #1;
    check(req, rdata, model[a]);
    chk1(req, q_drive, 1'b1);
    cyc();
  endtask

  task automatic desel();
    nop(); start_ctl_n = 1'b0; en_hi = 1'b0; cyc();
    nop(); cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] old;
    int b, x, z, q;
    nop(); addr = '0; order_ilv = 1'b0; doze = 1'b0; rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0; #1;
    chk1("R1 drive after reset", q_drive, 1'b0);
    for (int i = 0; i < 3; i++) begin
      nop(); step_n = 1'b0; wr_all_n = i[0]; cyc();
      nop(); #1;
      chk1("R1 no access before a burst", q_drive, 1'b0);
    end

    // R4: controller-strobe single-cycle writes fill the whole array; step ignored
    for (int a = 0; a < DEPTH; a++) begin
      nop(); start_ctl_n = 1'b0; addr = AW'(a); wr_all_n = 1'b0;
      step_n = a[0]; wdata = pat(a, 0); model[a] = pat(a, 0);
      cyc();
    end

    // R10: back-to-back single reads across every address
    for (int a = 0; a < DEPTH; a++) begin
      nop(); start_ctl_n = 1'b0; addr = AW'(a); cyc(); #1;
      if (a == 0) chk1("R10 no drive before first data", q_drive, 1'b0);
      else begin
        check("R4 R10 read sweep", rdata, model[a-1]);
        chk1("R10 drive during sweep", q_drive, 1'b1);
      end
    end
    // R12: deselect after a read
    nop(); start_ctl_n = 1'b0; en_hi = 1'b0; cyc();
    nop(); #1;
    check("R12 data after deselect edge", rdata, model[DEPTH-1]);
    chk1("R12 drive after deselect edge", q_drive, 1'b1);
    cyc(); #1;
    chk1("R12 drive off one edge later", q_drive, 1'b0);

    // R10 first cycle after reselect, R11 output enable
    nop(); start_cpu_n = 1'b0; addr = 8'd5; cyc();
    nop(); #1;
    chk1("R10 first cycle after select", q_drive, 1'b0);
    cyc(); #1;
    check("R10 data one edge later", rdata, model[5]);
    chk1("R10 drive one edge later", q_drive, 1'b1);
    out_en_n = 1'b1; #1;
    chk1("R11 out_en_n high", q_drive, 1'b0);
    out_en_n = 1'b0; #1;
    chk1("R11 out_en_n low again", q_drive, 1'b1);
    desel();

    // R7 / R8 burst orders incl. wrap after four, R6 advance
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        b = 16 + m * 4 + s;
        order_ilv = m[0];
        nop(); start_cpu_n = 1'b0; addr = AW'(b * 4 + s); cyc();
        for (int i = 1; i <= 5; i++) begin
          nop();
          if (i < 5) step_n = 1'b0;
          else begin start_ctl_n = 1'b0; en_lo1_n = 1'b1; end
          cyc(); #1;
          if (m == 1) check("R7 interleaved order", rdata, model[b * 4 + lowb(s, i - 1, m)]);
          else        check("R8 linear order", rdata, model[b * 4 + lowb(s, i - 1, m)]);
        end
        nop(); cyc();
      end
    end

    // R6 suspend then advance (linear, start bits 1)
    begin
      int exp_low [5] = '{1, 1, 1, 2, 3};
      bit sn [5] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
      order_ilv = 1'b0;
      b = 40;
      nop(); start_cpu_n = 1'b0; addr = AW'(b * 4 + 1); cyc();
      for (int i = 1; i <= 5; i++) begin
        nop();
        if (i < 5) step_n = sn[i];
        else begin start_ctl_n = 1'b0; en_hi = 1'b0; end
        cyc(); #1;
        check("R6 suspend and advance", rdata, model[b * 4 + exp_low[i-1]]);
      end
      nop(); cyc();
    end

    // R5 two-cycle processor write, R6 continue write, R11 drive off during write
    x = 144;
    old = model[x];
    nop(); start_cpu_n = 1'b0; addr = AW'(x); wr_all_n = 1'b0; wdata = pat(1, 9); cyc();
    nop(); wr_all_n = 1'b0; wdata = pat(x, 1); cyc();
    model[x] = pat(x, 1);
    nop(); wr_lane_n = 1'b0; lane_sel_n = 4'b1010; step_n = 1'b0; wdata = pat(x, 2); #1;
    check("R5 opening cycle was a read", rdata, old);
    chk1("R11 drive off while write presented", q_drive, 1'b0);
    cyc();
    for (int l = 0; l < NL; l++)
      if (l == 0 || l == 2) model[x+1][l*LW +: LW] = pat(x, 2) >> (l * LW);
    desel();
    rd_chk(x, "R5 second-edge write");
    rd_chk(x + 1, "R6 continue write masked");

    // R9 exhaustive lane-select sweep
    z = 160;
    for (int m = 0; m < 16; m++) begin
      nop(); start_ctl_n = 1'b0; addr = AW'(z); wr_lane_n = 1'b0;
      lane_sel_n = ~NL'(m); wdata = pat(m, 3); cyc();
      for (int l = 0; l < NL; l++)
        if (m[l]) model[z][l*LW +: LW] = pat(m, 3) >> (l * LW);
      rd_chk(z, "R9 lane mask");
    end
    nop(); start_ctl_n = 1'b0; addr = AW'(z); wr_all_n = 1'b0; lane_sel_n = '1;
    wdata = pat(z, 4); cyc();
    model[z] = pat(z, 4);
    rd_chk(z, "R9 global write overrides");
    nop(); start_ctl_n = 1'b0; addr = AW'(z); lane_sel_n = '0; wdata = pat(z, 5); cyc();
    rd_chk(z, "R9 no write enable is a read");

    // R3 both strobes low: read wins over write controls
    x = 170;
    nop(); start_cpu_n = 1'b0; start_ctl_n = 1'b0; addr = AW'(x);
    wr_all_n = 1'b0; wdata = pat(7, 7); cyc();
    nop(); start_ctl_n = 1'b0; en_hi = 1'b0; cyc();
    nop(); #1;
    check("R3 both strobes give a read", rdata, model[x]);
    chk1("R3 both strobes drive", q_drive, 1'b1);
    cyc();
    rd_chk(x, "R3 no write on both strobes");

    // R3 processor strobe masked by en_lo0_n: acts as a continue cycle
    order_ilv = 1'b0;
    x = 180;
    nop(); start_ctl_n = 1'b0; addr = AW'(x); cyc();
    nop(); start_cpu_n = 1'b0; en_lo0_n = 1'b1; step_n = 1'b0; addr = 8'd0; cyc();
    nop(); start_ctl_n = 1'b0; en_hi = 1'b0; cyc();
    nop(); #1;
    check("R3 masked processor strobe continues", rdata, model[x + 1]);
    cyc();

    // R2 each enable inactive deselects; later continues do nothing
    for (int e = 0; e < 4; e++) begin
      nop(); start_ctl_n = 1'b0; addr = AW'(200 + e); cyc();
      nop();
      if (e == 3) begin start_cpu_n = 1'b0; en_hi = 1'b0; end
      else begin
        start_ctl_n = 1'b0;
        if (e == 0) en_lo0_n = 1'b1;
        if (e == 1) en_hi = 1'b0;
        if (e == 2) en_lo1_n = 1'b1;
      end
      cyc();
      nop(); cyc(); #1;
      chk1("R2 deselect turns drive off", q_drive, 1'b0);
      nop(); step_n = 1'b0; cyc();
      nop(); step_n = 1'b0; cyc(); #1;
      chk1("R2 no access after deselect", q_drive, 1'b0);
    end

    // R13 sleep: entry with an open burst, ignored accesses, exit latency
    q = 195;
    nop(); doze = 1'b1; start_ctl_n = 1'b0; addr = AW'(q); cyc();
    nop(); doze = 1'b1; cyc();
    nop(); doze = 1'b1; start_ctl_n = 1'b0; addr = AW'(q); wr_all_n = 1'b0; wdata = ~model[q]; cyc();
    nop(); doze = 1'b1; #1;
    chk1("R13 drive off once asleep", q_drive, 1'b0);
    start_cpu_n = 1'b0; addr = AW'(q); cyc();
    nop(); doze = 1'b1; cyc(); #1;
    chk1("R13 no read while asleep", q_drive, 1'b0);
    nop(); doze = 1'b0; start_ctl_n = 1'b0; addr = AW'(q); wr_all_n = 1'b0; wdata = ~model[q]; cyc();
    nop(); start_ctl_n = 1'b0; addr = AW'(q); wr_all_n = 1'b0; wdata = ~model[q]; cyc();
    nop(); step_n = 1'b0; wr_all_n = 1'b0; wdata = ~model[q + 1]; cyc();
    nop(); step_n = 1'b0; cyc(); #1;
    chk1("R13 burst dropped across sleep", q_drive, 1'b0);
    nop(); cyc();
    rd_chk(q, "R13 contents kept and exit writes ignored");
    rd_chk(q + 1, "R13 dropped burst wrote nothing");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule